// File: doc/BRIEF.md
# Four-Channel DMA Register File

This block is the processor-side register file of a four-channel DMA controller. A host with an 8-bit data bus reaches it through an active-low chip select, active-low read and write strobes and a 4-bit register address. Each channel holds a 16-bit memory pointer and a 16-bit transfer count. Each of these is loaded as two bytes through a single address, steered by one byte-order toggle that all channel registers share. A mode byte and a read-only status byte complete the map. The stored pointers, counts and mode bits go straight out to the transfer engine.

The transfer engine reports back by pulsing a per-channel count-expired input and a reload-done input. The block holds these as sticky status flags. A completed status read clears them. Software is expected to load the channel pointers and counts first, then the mode byte.

Each strobe period counts as one access. A write commits on the first clock edge where the strobe is seen active. Read data is driven combinationally while the read strobe is active. The side effects of a read (toggle advance, flag clear) occur on the clock edge where the read is seen to have ended.

Top module: `dma_regfile`

## Requirements
- R1: After reset every channel pointer, every count, the mode byte, all status flags and the byte toggle are 0, so the next channel access uses the low byte.
- R2: With `cs_n` high, write and read strobes have no effect: no register changes, the toggle does not move and `rd_data` stays 0.
- R3: With address bit 3 at 0, address bits 2:1 select the channel and address bit 0 selects the register: 0 is the memory pointer and 1 is the transfer count.
- R4: A channel register write stores `wr_data` in the low byte when the toggle is 0 and in the high byte when it is 1. Every channel register write flips the shared toggle.
- R5: A channel register read returns the low byte when the toggle is 0 and the high byte when it is 1. The toggle flips when the read strobe ends.
- R6: A write to address 1000 loads the mode byte onto `mode` (bits 3:0 enable channels 3..0, bit 4 rotating priority, bit 5 extended write, bit 6 stop on count, bit 7 auto-reload). Writes to addresses 1001..1111 change nothing.
- R7: A read with address bit 3 at 1 returns the status byte: bits 3:0 are the count-expired flags of channels 3..0, bit 4 is the reload-done flag, and bits 7:5 are 0.
- R8: A pulse on `tc_hit[i]` or `reload_done` sets its flag, which holds until a status read ends and is then cleared. A set in the same cycle as that clear wins.
- R9: A strobe held active for several cycles performs exactly one write.
- R10: `rd_data` is 0 whenever no read is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 4 | Register address |
| wr_data | input | 8 | Write data byte |
| rd_data | output | 8 | Read data byte, 0 when idle |
| tc_hit | input | 4 | Per-channel count-expired pulse from the transfer engine |
| reload_done | input | 1 | Reload-done pulse from the transfer engine |
| mode | output | 8 | Stored mode byte |
| chan_ptr | output | 64 | Memory pointers, channel n at bits 16n+15:16n |
| chan_cnt | output | 64 | Transfer counts, channel n at bits 16n+15:16n |

## Verification
Register contents, `mode` and the flags change on the first rising edge at which a write strobe or event pulse is sampled. The bench therefore drives every input at a falling edge and checks ports only after the following rising edge. `rd_data` is combinational, so it is sampled a few nanoseconds after the read strobe is driven, inside the same cycle. The toggle advance and flag clear of a read land one rising edge after the strobe is released. Each read task therefore waits out that edge before the next access, and the clear-versus-set case places its event pulse on exactly that edge.

// File: rtl/dma_regfile.sv
module dma_regfile #(
  parameter int NCH = 4,
  parameter int RW  = 16,
  parameter int DW  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [3:0]        addr,
  input  logic [DW-1:0]     wr_data,
  output logic [DW-1:0]     rd_data,
  input  logic [NCH-1:0]    tc_hit,
  input  logic              reload_done,
  output logic [DW-1:0]     mode,
  output logic [NCH*RW-1:0] chan_ptr,
  output logic [NCH*RW-1:0] chan_cnt
);
  localparam int CW = $clog2(NCH);

  logic [NCH-1:0][RW-1:0] ptr_q, cnt_q;
  logic [NCH-1:0]         tcf_q;
  logic                   upd_q, tgl_q;
  logic                   wr_act_q, rd_act_q;
  logic [3:0]             rd_addr_q;
  logic [DW-1:0]          mode_q;

  wire          wr_act  = !cs_n && !wr_n;
  wire          rd_act  = !cs_n && !rd_n;
  wire          wr_go   = wr_act && !wr_act_q;
  wire          rd_end  = rd_act_q && !rd_act;
  wire          ch_wr   = wr_go && !addr[3];
  wire          ch_rend = rd_end && !rd_addr_q[3];
  wire          st_rend = rd_end && rd_addr_q[3];
  wire [CW-1:0] sel     = addr[CW:1];

  assign chan_ptr = ptr_q;
  assign chan_cnt = cnt_q;
  assign mode     = mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q     <= '0;
      cnt_q     <= '0;
      tcf_q     <= '0;
      upd_q     <= 1'b0;
      tgl_q     <= 1'b0;
      wr_act_q  <= 1'b0;
      rd_act_q  <= 1'b0;
      rd_addr_q <= '0;
      mode_q    <= '0;
    end else begin
      wr_act_q <= wr_act;
      rd_act_q <= rd_act;
      if (rd_act) rd_addr_q <= addr;
      tgl_q <= tgl_q ^ ch_wr ^ ch_rend;
      if (wr_go && addr == 4'b1000) mode_q <= wr_data;
      if (ch_wr) begin
        if (addr[0]) begin
          if (tgl_q) cnt_q[sel][RW-1:DW] <= wr_data;
          else       cnt_q[sel][DW-1:0]  <= wr_data;
        end else begin
          if (tgl_q) ptr_q[sel][RW-1:DW] <= wr_data;
          else       ptr_q[sel][DW-1:0]  <= wr_data;
        end
      end
      tcf_q <= (tcf_q & ~{NCH{st_rend}}) | tc_hit;
      upd_q <= (upd_q & ~st_rend) | reload_done;
    end
  end

  logic [RW-1:0] word;
  always_comb begin
    word    = addr[0] ? cnt_q[sel] : ptr_q[sel];
    rd_data = '0;
    if (rd_act) begin
      if (addr[3]) rd_data = DW'({upd_q, tcf_q});
      else         rd_data = tgl_q ? word[RW-1:DW] : word[DW-1:0];
    end
  end

  AST_NO_CS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> ($stable(chan_ptr) && $stable(chan_cnt) && $stable(mode))); // R2
  AST_TOGGLE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_act && !rd_act_q) |=> $stable(tgl_q)); // R4
  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_go && addr == 4'b1000) |=> $stable(mode)); // R6
  AST_STATUS_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_act && addr[3]) |-> rd_data[DW-1:NCH+1] == '0); // R7
  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (|tc_hit) |=> (tcf_q & $past(tc_hit)) == $past(tc_hit)); // R8
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !st_rend |=> (tcf_q & $past(tcf_q)) == $past(tcf_q)); // R8
  AST_ONE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_act && wr_act_q && !rd_act_q) |=> $stable(tgl_q)); // R9
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_n || cs_n) |-> rd_data == '0); // R10
endmodule

// File: tb/dma_regfile_bench.sv
module dma_regfile_bench;
  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [3:0]  addr = '0;
  logic [7:0]  wr_data = '0, rd_data, mode;
  logic [3:0]  tc_hit = '0;
  logic        reload_done = 1'b0;
  logic [63:0] chan_ptr, chan_cnt;
  int tests = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dma_regfile u_dma_regfile (.clk, .rst_n, .cs_n, .rd_n, .wr_n, .addr, .wr_data,
    .rd_data, .tc_hit, .reload_done, .mode, .chan_ptr, .chan_cnt);

  localparam int NV = 21;
  localparam logic [20:0] VEC [NV] = '{
    {1'b0,4'h0,8'h34,8'h00}, {1'b0,4'h0,8'h12,8'h00},
    {1'b0,4'h1,8'h78,8'h00}, {1'b0,4'h1,8'h56,8'h00},
    {1'b0,4'h2,8'hCD,8'h00}, {1'b0,4'h2,8'hAB,8'h00},
    {1'b0,4'h7,8'hEF,8'h00}, {1'b0,4'h7,8'hBE,8'h00},
    {1'b0,4'h8,8'h0F,8'h00}, {1'b0,4'h9,8'hFF,8'h00},
    {1'b1,4'h0,8'h00,8'h34}, {1'b1,4'h0,8'h00,8'h12},
    {1'b1,4'h7,8'h00,8'hEF}, {1'b1,4'h7,8'h00,8'hBE},
    {1'b1,4'h2,8'h00,8'hCD}, {1'b1,4'h2,8'h00,8'hAB},
    {1'b1,4'h1,8'h00,8'h78}, {1'b1,4'h1,8'h00,8'h56},
    {1'b1,4'h8,8'h00,8'h00}, {1'b1,4'h3,8'h00,8'h00},
    {1'b1,4'h3,8'h00,8'h00}
  };

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d, int hold = 1);
    @(negedge clk); cs_n = 0; wr_n = 0; addr = a; wr_data = d;
    repeat (hold) @(negedge clk);
    cs_n = 1; wr_n = 1;
  endtask

  task automatic rd(logic [3:0] a, output logic [7:0] d);
    @(negedge clk); cs_n = 0; rd_n = 0; addr = a;
    #2 d = rd_data;
    @(negedge clk); cs_n = 1; rd_n = 1;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    check("R1 ptr reset", chan_ptr, 64'h0);
    check("R1 cnt reset", chan_cnt, 64'h0);
    check("R1 mode reset", {56'h0, mode}, 64'h0);
    rst_n = 1;
    rd(4'h8, d); check("R1 status reset", {56'h0, d}, 64'h0);

    // R3 R4 R5 R6 R7: table of writes and read-backs
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][20]) begin
        rd(VEC[i][19:16], d);
        check($sformatf("R5 R3 row %0d", i), {56'h0, d}, {56'h0, VEC[i][7:0]});
      end else wr(VEC[i][19:16], VEC[i][15:8]);
    end
    @(negedge clk);
    check("R3 ch0 ptr", {48'h0, chan_ptr[15:0]}, 64'h1234);
    check("R3 ch1 ptr", {48'h0, chan_ptr[31:16]}, 64'hABCD);
    check("R3 ch0 cnt", {48'h0, chan_cnt[15:0]}, 64'h5678);
    check("R3 ch3 cnt", {48'h0, chan_cnt[63:48]}, 64'hBEEF);
    check("R6 mode kept after 1001", {56'h0, mode}, 64'h0F);

    // R2: deselected strobes
    @(negedge clk); cs_n = 1; wr_n = 0; addr = 0; wr_data = 8'h55;
    repeat (2) @(negedge clk); wr_n = 1; rd_n = 0;
    #2 check("R2 read deselected", {56'h0, rd_data}, 64'h0);
    @(negedge clk); rd_n = 1; @(negedge clk);
    check("R2 ptr untouched", {48'h0, chan_ptr[15:0]}, 64'h1234);
    wr(4'h0, 8'h11); wr(4'h0, 8'h22); @(negedge clk);
    check("R4 toggle unmoved by R2", {48'h0, chan_ptr[15:0]}, 64'h2211);

    // R9: held strobe
    wr(4'h4, 8'h05, 3); wr(4'h4, 8'h06); @(negedge clk);
    check("R9 held write once", {48'h0, chan_ptr[47:32]}, 64'h0605);

    // R5: a single read advances the toggle
    rd(4'h0, d); check("R5 low byte", {56'h0, d}, 64'h11);
    wr(4'h0, 8'hAA); @(negedge clk);
    check("R5 toggle advanced", {48'h0, chan_ptr[15:0]}, 64'hAA11);

    // R8 R7: flags
    @(negedge clk); tc_hit = 4'b0101; @(negedge clk); tc_hit = 0;
    rd(4'h8, d); check("R8 flags set", {56'h0, d}, 64'h05);
    rd(4'h8, d); check("R8 flags cleared", {56'h0, d}, 64'h00);
    @(negedge clk); cs_n = 0; rd_n = 0; addr = 4'h8;
    @(negedge clk); cs_n = 1; rd_n = 1; tc_hit = 4'b1000;
    @(negedge clk); tc_hit = 0;
    rd(4'h8, d); check("R8 set beats clear", {56'h0, d}, 64'h08);
    @(negedge clk); reload_done = 1; @(negedge clk); reload_done = 0;
    rd(4'hC, d); check("R7 reload flag bit4", {56'h0, d}, 64'h10);
    rd(4'h8, d); check("R7 status cleared", {56'h0, d}, 64'h00);

    @(negedge clk); #2 check("R10 idle data", {56'h0, rd_data}, 64'h0);
    finish_run();
  end
endmodule